// File: doc/BRIEF.md
# Programmable Multi-Mode Timer Channel

This block is a single programmable timer channel built around a 16-bit down-counter. A register block upstream hands it a count value, a three-bit operating mode and a binary/BCD select, together with a one-cycle strobe that marks a fresh write. The channel then generates an output waveform on `tmr_out` according to the chosen mode. In some modes the `gate` input acts as a level enable. In the others a rising edge on `gate` starts or restarts the count.

Two modes repeat on their own: the rate generator and the square wave generator reload the count after each period. The other modes are one-shot timers or strobes that run once per write or per gate edge. A programmed count of zero stands for the full range of the counter: 65536 counts in binary or 10000 in BCD. The live counter value is always visible on `count_now`, so an external latch can capture it while counting goes on.

The counter advances on the rising edge of `clk`, one step per edge. Reset is synchronous and active high.

Top module: `pit_channel`

## Requirements
- R1: After reset `tmr_out` is 1 and `count_now` is 0. The counter does not move until the first strobe, whatever `gate` does.
- R2: In modes 000, 010, 011 and 100 the programmed count appears on `count_now` one clock after the strobe. While counting is enabled it then drops by one on every clock.
- R3: Mode 000 (terminal-count flag): `tmr_out` goes low on the strobe edge. It goes high on the edge where the counter reaches 0, which is N+1 clocks after the strobe. It stays high until the next strobe. While `gate` is 0 the count is held.
- R4: Mode 001 (retriggerable one-shot): a rising edge of `gate` loads N and drives `tmr_out` low. `tmr_out` returns high N clocks later. A new rising edge before then reloads N and stretches the low pulse.
- R5: Mode 010 (rate generator): the first low clock on `tmr_out` comes N+1 clocks after the strobe. After that `tmr_out` is low for exactly one clock in every N, and the counter reloads N at each low clock.
- R6: Mode 011 (square wave): `tmr_out` repeats with period N. It is high for (N+1)/2 clocks and low for N/2 clocks, using integer division.
- R7: Mode 100 (software strobe): `tmr_out` is low for exactly one clock, on the edge where the counter reaches 0, which is N+1 clocks after the strobe. Otherwise it is high.
- R8: Mode 101 (gate-triggered strobe): a rising edge of `gate` loads N. `tmr_out` is low for exactly one clock, N clocks after that edge. A later rising edge re-arms the strobe.
- R9: In modes 010 and 011, `gate` at 0 forces `tmr_out` high on the next edge and freezes the counter. A rising edge of `gate` reloads N.
- R10: With `wr_bcd` = 0, a programmed count of 0 gives a period of 65536 clocks. The counter steps from 0 to FFFFh.
- R11: With `wr_bcd` = 1, each 4-bit digit borrows from 0 to 9. A programmed count of 0 steps to 9999h and gives a period of 10000 clocks.
- R12: The square wave also works in BCD. A count of 15h with `wr_bcd` = 1 is high for 8 clocks and low for 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_count | input | 16 | Count value to program (binary or packed BCD) |
| wr_strobe | input | 1 | One-cycle pulse: capture count, mode and number format |
| wr_mode | input | 3 | Operating mode, codes 000 to 101 |
| wr_bcd | input | 1 | 1 = count in BCD, 0 = binary |
| gate | input | 1 | Level enable or edge trigger, depending on mode |
| tmr_out | output | 1 | Registered channel output |
| count_now | output | 16 | Live value of the down-counter |

## Verification
The bench targets the boundaries of each count sequence. It checks the exact clock on which the terminal-count flag rises, the single-clock width of the rate and strobe pulses, and the uneven high/low split of an odd square wave in both binary and BCD. A design that reloads one clock late, or that halves the count the wrong way, shifts the sampled edges and is reported. The zero count is run to its full 65536 and 10000 periods, so a counter that treats zero as an empty count, or that wraps a BCD digit to Fh, fails there. Gate handling is checked in four ways: pausing, forcing the output high, reloading on a rising edge, and retriggering a one-shot while it is still running. Each of these catches a mode that confuses level-enable with edge-trigger behaviour.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_TC_FLAG   = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } pit_mode_e;

  localparam int DIGIT_W = 4;

endpackage

// File: rtl/pit_decrement.sv
`timescale 1ns/1ps
module pit_decrement #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cur_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] nxt_o
);
  localparam int DIGITS = CNT_W / pit_pkg::DIGIT_W;

  // A digit borrows when every digit below it is zero; this avoids a ripple chain.
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    logic [3:0] wrap_val;
    logic       lower_zero;

    assign d        = cur_i[4*g +: 4];
    assign wrap_val = bcd_i ? 4'd9 : 4'hF;

    if (g == 0) begin : g_lsd
      assign lower_zero = 1'b1;
    end else begin : g_upper
      assign lower_zero = (cur_i[4*g-1:0] == '0);
    end

    assign nxt_o[4*g +: 4] = !lower_zero ? d :
                             (d == 4'd0) ? wrap_val : (d - 4'd1);
  end

endmodule

// File: rtl/pit_half.sv
`timescale 1ns/1ps
module pit_half #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] half_o
);
  localparam int DIGITS = CNT_W / pit_pkg::DIGIT_W;

  logic [CNT_W-1:0] bcd_half;
  logic [CNT_W-1:0] bcd_full_half;
  logic [CNT_W-1:0] bin_full_half;

  // Halving packed BCD: each digit halves, plus 5 if the digit above is odd.
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    logic       carry5;
    assign d = val_i[4*g +: 4];
    if (g == DIGITS - 1) begin : g_msd
      assign carry5 = 1'b0;
    end else begin : g_lower
      assign carry5 = val_i[4*(g+1)];
    end
    assign bcd_half[4*g +: 4] = {1'b0, d[3:1]} + (carry5 ? 4'd5 : 4'd0);
  end

  // A zero load stands for full scale; its half is 5 in the top digit or the top bit.
  assign bcd_full_half = {4'd5, {(CNT_W-4){1'b0}}};
  assign bin_full_half = {1'b1, {(CNT_W-1){1'b0}}};

  always_comb begin
    if (val_i == '0) begin
      half_o = bcd_i ? bcd_full_half : bin_full_half;
    end else begin
      half_o = bcd_i ? bcd_half : (val_i >> 1);
    end
  end

endmodule

// File: rtl/pit_ctrl.sv
`timescale 1ns/1ps
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb_i,
  input  logic [2:0]       load_mode_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] dec_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             out_q
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic             pend_q, run_q, armed_q, loaded_q, gate_q;
  logic             pend_n, run_n, armed_n, loaded_n, out_n;
  logic [CNT_W-1:0] cnt_n;
  logic             gate_rise;
  logic             edge_start;

  assign gate_rise = gate_i & ~gate_q;

  // Edge-started modes skip the copy cycle and wait for a gate edge.
  assign edge_start = (load_mode_i == MODE_ONESHOT) || (load_mode_i == MODE_HW_STROBE);

  always_comb begin
    cnt_n    = cnt_q;
    out_n    = out_q;
    pend_n   = pend_q;
    run_n    = run_q;
    armed_n  = armed_q;
    loaded_n = loaded_q;

    if (load_stb_i) begin
      loaded_n = 1'b1;
      run_n    = 1'b0;
      armed_n  = 1'b0;
      pend_n   = !edge_start;
      out_n    = (load_mode_i != MODE_TC_FLAG);
    end else if (pend_q) begin
      pend_n  = 1'b0;
      cnt_n   = hold_i;
      run_n   = 1'b1;
      armed_n = 1'b1;
      if (mode_i != MODE_TC_FLAG) out_n = 1'b1;
    end else begin
      case (pit_mode_e'(mode_i))
        MODE_TC_FLAG: begin
          if (run_q && gate_i) begin
            cnt_n = dec_i;
            if (dec_i == '0) out_n = 1'b1;
          end
        end
        MODE_ONESHOT: begin
          if (gate_rise && loaded_q) begin
            cnt_n = hold_i;
            out_n = 1'b0;
            run_n = 1'b1;
          end else if (run_q) begin
            cnt_n = dec_i;
            if (dec_i == '0) begin
              out_n = 1'b1;
              run_n = 1'b0;
            end
          end
        end
        MODE_RATE: begin
          if (!gate_i) begin
            out_n = 1'b1;
          end else if (gate_rise && loaded_q) begin
            cnt_n = hold_i;
            out_n = 1'b1;
            run_n = 1'b1;
          end else if (run_q) begin
            if (cnt_q == ONE) begin
              cnt_n = hold_i;
              out_n = 1'b0;
            end else begin
              cnt_n = dec_i;
              out_n = 1'b1;
            end
          end
        end
        MODE_SQUARE: begin
          if (!gate_i) begin
            out_n = 1'b1;
          end else if (gate_rise && loaded_q) begin
            cnt_n = hold_i;
            out_n = 1'b1;
            run_n = 1'b1;
          end else if (run_q) begin
            cnt_n = (cnt_q == ONE) ? hold_i : dec_i;
            out_n = (cnt_n == '0) || (cnt_n > half_i);
          end
        end
        MODE_SW_STROBE: begin
          out_n = 1'b1;
          if (run_q && gate_i) begin
            cnt_n = dec_i;
            if (armed_q && dec_i == '0) begin
              out_n   = 1'b0;
              armed_n = 1'b0;
            end
          end
        end
        MODE_HW_STROBE: begin
          out_n = 1'b1;
          if (gate_rise && loaded_q) begin
            cnt_n   = hold_i;
            run_n   = 1'b1;
            armed_n = 1'b1;
          end else if (run_q) begin
            cnt_n = dec_i;
            if (armed_q && dec_i == '0) begin
              out_n   = 1'b0;
              armed_n = 1'b0;
            end
          end
        end
        default: out_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      out_q    <= 1'b1;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      loaded_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      out_q    <= out_n;
      pend_q   <= pend_n;
      run_q    <= run_n;
      armed_q  <= armed_n;
      loaded_q <= loaded_n;
      gate_q   <= gate_i;
    end
  end

  // R2: the copy cycle moves the held count into the counter
  a_r2_copy_to_counter: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !load_stb_i) |=> (cnt_q == $past(hold_i)));

  // R3: a write in mode 000 drops the output on the next edge
  a_r3_low_after_write: assert property (@(posedge clk) disable iff (rst)
    (load_stb_i && load_mode_i == MODE_TC_FLAG) |=> !out_q);

  // R3: once high in mode 000 the output stays high until a write
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_TC_FLAG && out_q && !load_stb_i) |=> out_q);

  // R4: a gate rise in the one-shot reloads and drops the output
  a_r4_trigger_reload: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_ONESHOT && loaded_q && gate_i && !gate_q && !load_stb_i)
      |=> (!out_q && cnt_q == $past(hold_i)));

  // R5: count of one in the rate generator gives a low clock and a reload
  a_r5_rate_reload: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RATE && run_q && !pend_q && gate_i && gate_q && !load_stb_i && cnt_q == ONE)
      |=> (!out_q && cnt_q == $past(hold_i)));

  // R7, R8: a strobe pulse lasts a single clock
  a_r7_strobe_one_clock: assert property (@(posedge clk) disable iff (rst)
    (!out_q && (mode_i == MODE_SW_STROBE || mode_i == MODE_HW_STROBE) && !load_stb_i) |=> out_q);

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_strobe,
  input  logic [2:0]       wr_mode,
  input  logic             wr_bcd,
  input  logic             gate,
  output logic             tmr_out,
  output logic [CNT_W-1:0] count_now
);
  logic [CNT_W-1:0] hold_q, half_q, half_w, dec_w, cnt_w;
  logic [2:0]       mode_q;
  logic             bcd_q;
  logic             out_w;

  pit_half #(.CNT_W(CNT_W)) u_half (
    .val_i  (wr_count),
    .bcd_i  (wr_bcd),
    .half_o (half_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      half_q <= '0;
      mode_q <= 3'd0;
      bcd_q  <= 1'b0;
    end else if (wr_strobe) begin
      hold_q <= wr_count;
      half_q <= half_w;
      mode_q <= wr_mode;
      bcd_q  <= wr_bcd;
    end
  end

  pit_decrement #(.CNT_W(CNT_W)) u_dec (
    .cur_i (cnt_w),
    .bcd_i (bcd_q),
    .nxt_o (dec_w)
  );

  pit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load_stb_i  (wr_strobe),
    .load_mode_i (wr_mode),
    .mode_i      (mode_q),
    .hold_i      (hold_q),
    .half_i      (half_q),
    .dec_i       (dec_w),
    .gate_i      (gate),
    .cnt_q       (cnt_w),
    .out_q       (out_w)
  );

  assign tmr_out   = out_w;
  assign count_now = cnt_w;

  // R1: nothing counts before the first write after reset
  a_r1_idle_until_write: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wr_strobe) |=> (count_now == '0 && tmr_out));

endmodule

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wr_count = '0;
  logic        wr_strobe = 1'b0;
  logic [2:0]  wr_mode = 3'd0;
  logic        wr_bcd = 1'b0;
  logic        gate = 1'b0;
  logic        tmr_out;
  logic [15:0] count_now;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  pit_channel u_pit_channel (
    .clk       (clk),
    .rst       (rst),
    .wr_count  (wr_count),
    .wr_strobe (wr_strobe),
    .wr_mode   (wr_mode),
    .wr_bcd    (wr_bcd),
    .gate      (gate),
    .tmr_out   (tmr_out),
    .count_now (count_now)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] v, input logic [2:0] m, input logic b);
    wr_count  = v;
    wr_mode   = m;
    wr_bcd    = b;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic t_reset;
    gate = 1'b1;
    chk("R1 out after reset", {31'b0, tmr_out}, 1);
    chk("R1 count after reset", {16'b0, count_now}, 0);
    tick(5);
    chk("R1 no count before write", {16'b0, count_now}, 0);
    chk("R1 out idle", {31'b0, tmr_out}, 1);
  endtask

  task automatic t_flag;
    gate = 1'b1;
    do_load(16'd5, 3'd0, 1'b0);
    chk("R3 low on write", {31'b0, tmr_out}, 0);
    tick(1);
    chk("R2 copied count", {16'b0, count_now}, 5);
    tick(1);
    chk("R2 one step per clock", {16'b0, count_now}, 4);
    tick(3);
    chk("R3 still low before zero", {31'b0, tmr_out}, 0);
    tick(1);
    chk("R3 high at zero", {31'b0, tmr_out}, 1);
    chk("R3 count at zero", {16'b0, count_now}, 0);
    tick(3);
    chk("R3 stays high", {31'b0, tmr_out}, 1);
    gate = 1'b0;
    do_load(16'd4, 3'd0, 1'b0);
    tick(1);
    chk("R3 copied while gate low", {16'b0, count_now}, 4);
    tick(5);
    chk("R3 gate low holds count", {16'b0, count_now}, 4);
    gate = 1'b1;
    tick(1);
    chk("R3 resumes on gate", {16'b0, count_now}, 3);
  endtask

  task automatic t_oneshot;
    gate = 1'b0;
    do_load(16'd3, 3'd1, 1'b0);
    chk("R4 high after write", {31'b0, tmr_out}, 1);
    tick(2);
    chk("R4 waits for gate", {31'b0, tmr_out}, 1);
    gate = 1'b1;
    tick(1);
    chk("R4 trigger low", {31'b0, tmr_out}, 0);
    chk("R4 trigger loads", {16'b0, count_now}, 3);
    tick(2);
    chk("R4 low during run", {31'b0, tmr_out}, 0);
    tick(1);
    chk("R4 high after N", {31'b0, tmr_out}, 1);
    tick(3);
    chk("R4 no rerun without edge", {31'b0, tmr_out}, 1);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1);
    chk("R4 second trigger", {16'b0, count_now}, 3);
    tick(1);
    gate = 1'b0; tick(1);
    chk("R4 still counting", {16'b0, count_now}, 1);
    gate = 1'b1; tick(1);
    chk("R4 retrigger reload", {16'b0, count_now}, 3);
    chk("R4 retrigger low", {31'b0, tmr_out}, 0);
    tick(2);
    chk("R4 stretched low", {31'b0, tmr_out}, 0);
    tick(1);
    chk("R4 high after retrigger", {31'b0, tmr_out}, 1);
  endtask

  task automatic t_rate;
    logic [15:0] held;
    gate = 1'b1;
    do_load(16'd4, 3'd2, 1'b0);
    for (int i = 1; i <= 13; i++) begin
      tick(1);
      chk("R5 rate pulse", {31'b0, tmr_out}, (i >= 5 && (i - 5) % 4 == 0) ? 0 : 1);
    end
    gate = 1'b0;
    tick(1);
    chk("R9 gate low forces high", {31'b0, tmr_out}, 1);
    held = count_now;
    tick(3);
    chk("R9 gate low freezes", {16'b0, count_now}, {16'b0, held});
    gate = 1'b1;
    tick(1);
    chk("R9 gate rise reloads", {16'b0, count_now}, 4);
    tick(3);
    chk("R9 high before pulse", {31'b0, tmr_out}, 1);
    tick(1);
    chk("R9 pulse after reload", {31'b0, tmr_out}, 0);
  endtask

  task automatic t_square(input logic [15:0] v, input logic b, input int n, input int span, input string tag);
    gate = 1'b1;
    do_load(v, 3'd3, b);
    for (int i = 1; i <= span; i++) begin
      tick(1);
      chk(tag, {31'b0, tmr_out}, (((i - 1) % n) < ((n + 1) / 2)) ? 1 : 0);
    end
  endtask

  task automatic t_sw_strobe;
    gate = 1'b1;
    do_load(16'd3, 3'd4, 1'b0);
    chk("R7 high after write", {31'b0, tmr_out}, 1);
    tick(3);
    chk("R7 high before zero", {31'b0, tmr_out}, 1);
    tick(1);
    chk("R7 strobe low", {31'b0, tmr_out}, 0);
    chk("R7 count zero", {16'b0, count_now}, 0);
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk("R7 single strobe", {31'b0, tmr_out}, 1);
    end
  endtask

  task automatic t_hw_strobe;
    gate = 1'b0;
    do_load(16'd2, 3'd5, 1'b0);
    tick(2);
    chk("R8 waits for gate", {31'b0, tmr_out}, 1);
    gate = 1'b1;
    tick(1);
    chk("R8 loads on edge", {16'b0, count_now}, 2);
    tick(1);
    chk("R8 high before strobe", {31'b0, tmr_out}, 1);
    tick(1);
    chk("R8 strobe low", {31'b0, tmr_out}, 0);
    tick(1);
    chk("R8 strobe ends", {31'b0, tmr_out}, 1);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(2);
    chk("R8 rearmed high", {31'b0, tmr_out}, 1);
    tick(1);
    chk("R8 rearmed strobe", {31'b0, tmr_out}, 0);
  endtask

  task automatic t_zero_bin;
    int first_low;
    gate = 1'b1;
    do_load(16'd0, 3'd2, 1'b0);
    tick(1);
    chk("R10 zero copied", {16'b0, count_now}, 0);
    tick(1);
    chk("R10 zero wraps", {16'b0, count_now}, 16'hFFFF);
    first_low = 0;
    for (int i = 3; i <= 70000 && first_low == 0; i++) begin
      tick(1);
      if (!tmr_out) first_low = i;
    end
    chk("R10 full period", first_low, 65537);
  endtask

  task automatic t_bcd;
    int first_low;
    gate = 1'b1;
    do_load(16'h0010, 3'd0, 1'b1);
    tick(1);
    chk("R11 bcd copied", {16'b0, count_now}, 16'h0010);
    tick(1);
    chk("R11 digit borrow to 9", {16'b0, count_now}, 16'h0009);
    do_load(16'h0000, 3'd2, 1'b1);
    tick(2);
    chk("R11 zero to 9999", {16'b0, count_now}, 16'h9999);
    first_low = 0;
    for (int i = 3; i <= 12000 && first_low == 0; i++) begin
      tick(1);
      if (!tmr_out) first_low = i;
    end
    chk("R11 bcd full period", first_low, 10001);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_flag();
    t_oneshot();
    t_rate();
    t_square(16'd5, 1'b0, 5, 15, "R6 odd square");
    t_square(16'd4, 1'b0, 4, 12, "R6 even square");
    t_square(16'h0015, 1'b1, 15, 30, "R12 bcd square");
    t_sw_strobe();
    t_hw_strobe();
    t_zero_bin();
    t_bcd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule